// File: doc/BRIEF.md
# Dual-Address Masked I2C Address Matcher

This block sits behind the bit-level receiver of an I2C target that answers on up to two 7-bit addresses. When the receiver presents the first byte of a transfer with a one-cycle valid strobe, the block runs two comparisons. The first is a coarse compare under a bit mask. In two-address mode, every bit position in which the two configured addresses differ is treated as don't-care. A hit raises a match pulse that the rest of the target can use as a wake-up, so the compare can run while the rest of the target is idle.

The second comparison is exact, against both configured addresses. It decides whether the address is acknowledged, and it reports which of the two addresses was hit. Because the mask can let through aliases that are neither address, the exact stage is what rejects them. In that case the coarse pulse is still raised, but no acknowledge follows. The direction bit of the received byte is passed through alongside the result.

All results are registered one cycle after the strobe and are zero in every other cycle.

Top module: `dual_addr_matcher`

## Requirements
- R1: The 7-bit address is taken from bits [7:1] of the received byte. Bit 0 is reported on `rw` in the cycle after the strobe (1 = read, 0 = write).
- R2: In single-address mode (`dual_mode` = 0), every address bit is significant. `coarse_match` and `ack` are both 1 only when bits [7:1] equal the primary address.
- R3: In two-address mode, bits where primary and secondary differ are don't-care for `coarse_match`. With k differing bits, exactly 2^k of the 128 addresses give a coarse match.
- R4: In two-address mode, `ack` is 1 only for the exact primary or exact secondary address. A coarse-matched alias gives `coarse_match` = 1 with `ack` = 0.
- R5: When both exact compares hit, because the two addresses are equal, the primary wins: `ack` = 1 and `select_secondary` = 0.
- R6: `select_secondary` is 1, together with `ack`, only on an exact hit of the secondary address in two-address mode. A primary hit gives `select_secondary` = 0.
- R7: All outputs take their value in the cycle after a valid strobe. In a cycle that does not follow a strobe, all outputs are 0, whatever `rx_byte` holds.
- R8: After synchronous reset, all outputs are 0.
- R9: In single-address mode, the secondary address has no effect: a byte carrying the secondary address gives `coarse_match` = 0, `ack` = 0 and `select_secondary` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid | input | 1 | One-cycle strobe marking `rx_byte` as an address byte |
| rx_byte | input | 8 | Received address byte: address in [7:1], direction in [0] |
| primary_addr | input | 7 | Primary 7-bit address, right-justified |
| secondary_addr | input | 7 | Secondary 7-bit address, right-justified |
| dual_mode | input | 1 | 1 = answer on both addresses, 0 = primary only |
| coarse_match | output | 1 | Masked compare hit (wake indication) |
| ack | output | 1 | Exact compare hit; acknowledge the address |
| select_secondary | output | 1 | The exact hit was the secondary address |
| rw | output | 1 | Direction bit of the received byte |

## Verification
The matcher is swept over all 128 addresses for address pairs that differ in one bit and in two bits. Counting coarse hits and acknowledges across each sweep separates a correct XOR mask from a mask that is too wide or too narrow. The two-bit pair also exposes aliases that must raise the wake pulse without an acknowledge.

Single-address mode is driven with the secondary address on the bus, to show that the second address is really switched off. An equal-address pair isolates the primary priority. Cycles with data on `rx_byte` but no strobe confirm that the outputs stay quiet.

// File: rtl/addr_match_pkg.sv
package addr_match_pkg;
    parameter int ADDR_W = 7;
    localparam int BYTE_W = ADDR_W + 1;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic coarse;
        logic ack;
        logic sec;
        logic rw;
    } match_res_t;

    // Significant-bit mask: all ones for one address, XNOR of both for two.
    function automatic addr_t build_mask(input addr_t a, input addr_t b, input logic dual);
        return dual ? ~(a ^ b) : '1;
    endfunction
endpackage

// File: rtl/coarse_cmp.sv
module coarse_cmp
    import addr_match_pkg::*;
(
    input  addr_t rx_addr,
    input  addr_t ref_addr,
    input  addr_t care_mask,
    output logic  hit
);
    addr_t diff;
    always_comb begin
        diff = (rx_addr ^ ref_addr) & care_mask;
        hit  = (diff == '0);
    end
endmodule

// File: rtl/exact_cmp.sv
module exact_cmp
    import addr_match_pkg::*;
#(
    parameter int NUM_REF = 2
) (
    input  addr_t              rx_addr,
    input  addr_t              ref_addr [NUM_REF],
    input  logic [NUM_REF-1:0] ref_en,
    output logic [NUM_REF-1:0] hit_vec
);
    for (genvar i = 0; i < NUM_REF; i++) begin : g_ref
        assign hit_vec[i] = ref_en[i] && (rx_addr == ref_addr[i]);
    end
endmodule

// File: rtl/dual_addr_matcher.sv
module dual_addr_matcher
    import addr_match_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] primary_addr,
    input  logic [ADDR_W-1:0] secondary_addr,
    input  logic              dual_mode,
    output logic              coarse_match,
    output logic              ack,
    output logic              select_secondary,
    output logic              rw
);
    localparam int NUM_REF = 2;

    addr_t              rx_addr;
    addr_t              care_mask;
    addr_t              refs [NUM_REF];
    logic [NUM_REF-1:0] ref_en;
    logic [NUM_REF-1:0] exact_hit;
    logic               coarse_hit;
    match_res_t         nxt, cur;

    assign rx_addr   = rx_byte[BYTE_W-1:1];
    assign care_mask = build_mask(primary_addr, secondary_addr, dual_mode);
    assign refs[0]   = primary_addr;
    assign refs[1]   = secondary_addr;
    assign ref_en    = {dual_mode, 1'b1};

    coarse_cmp u_coarse (
        .rx_addr  (rx_addr),
        .ref_addr (primary_addr),
        .care_mask(care_mask),
        .hit      (coarse_hit)
    );

    exact_cmp #(.NUM_REF(NUM_REF)) u_exact (
        .rx_addr (rx_addr),
        .ref_addr(refs),
        .ref_en  (ref_en),
        .hit_vec (exact_hit)
    );

    always_comb begin
        nxt = '0;
        if (addr_valid) begin
            nxt.coarse = coarse_hit;
            nxt.ack    = |exact_hit;
            nxt.sec    = exact_hit[1] && !exact_hit[0];
            nxt.rw     = rx_byte[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign coarse_match     = cur.coarse;
    assign ack              = cur.ack;
    assign select_secondary = cur.sec;
    assign rw               = cur.rw;

    assert_ack_needs_coarse_R4: assert property (@(posedge clk) disable iff (rst)
        ack |-> coarse_match);
    assert_sec_with_ack_R6: assert property (@(posedge clk) disable iff (rst)
        select_secondary |-> ack);
    assert_quiet_without_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        !addr_valid |=> !(coarse_match || ack || select_secondary || rw));
    assert_single_exact_R2: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && !dual_mode) |=> (coarse_match == ack) && !select_secondary);
    assert_dir_passthru_R1: assert property (@(posedge clk) disable iff (rst)
        addr_valid |=> rw == $past(rx_byte[0]));
endmodule

// File: tb/dual_addr_matcher_test.sv
module dual_addr_matcher_test;
    logic       clk = 0;
    logic       rst = 1;
    logic       addr_valid = 0;
    logic [7:0] rx_byte = '0;
    logic [6:0] primary_addr = '0;
    logic [6:0] secondary_addr = '0;
    logic       dual_mode = 0;
    logic       coarse_match, ack, select_secondary, rw;
    int         n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    dual_addr_matcher uut (
        .clk(clk), .rst(rst), .addr_valid(addr_valid), .rx_byte(rx_byte),
        .primary_addr(primary_addr), .secondary_addr(secondary_addr),
        .dual_mode(dual_mode), .coarse_match(coarse_match), .ack(ack),
        .select_secondary(select_secondary), .rw(rw)
    );

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {coarse,ack,sec,rw} got %b expected %b", req, got, exp);
        end
    endtask

    task automatic check_int(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Strobe one byte at a negedge; results are read at the following negedge.
    task automatic probe(input logic [6:0] a, input logic dir, output logic [3:0] res);
        @(negedge clk);
        rx_byte = {a, dir};
        addr_valid = 1;
        @(negedge clk);
        addr_valid = 0;
        res = {coarse_match, ack, select_secondary, rw};
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R8 reset", {coarse_match, ack, select_secondary, rw}, 4'b0000);
    endtask

    task automatic t_single;
        logic [3:0] r;
        primary_addr = 7'h24; secondary_addr = 7'h34; dual_mode = 0;
        probe(7'h24, 1'b1, r); check("R2 primary hit", r, 4'b1101);
        probe(7'h24, 1'b0, r); check("R1 write dir", r, 4'b1100);
        probe(7'h25, 1'b1, r); check("R2 neighbour miss", r, 4'b0001);
        probe(7'h34, 1'b0, r); check("R9 secondary ignored", r, 4'b0000);
    endtask

    task automatic t_sweep(input logic [6:0] p, input logic [6:0] s,
                           input int exp_coarse, input string req);
        logic [3:0] r;
        int nc = 0, na = 0;
        primary_addr = p; secondary_addr = s; dual_mode = 1;
        for (int i = 0; i < 128; i++) begin
            probe(7'(i), 1'b0, r);
            if (r[3]) nc++;
            if (r[2]) na++;
        end
        check_int({req, " coarse count"}, nc, exp_coarse);
        check_int("R4 ack count", na, 2);
    endtask

    task automatic t_dual_two_bit;
        logic [3:0] r;
        primary_addr = 7'h24; secondary_addr = 7'h30; dual_mode = 1;
        probe(7'h24, 1'b0, r); check("R6 primary no sec", r, 4'b1100);
        probe(7'h30, 1'b1, r); check("R6 secondary hit", r, 4'b1111);
        probe(7'h20, 1'b0, r); check("R4 alias 0x20", r, 4'b1000);
        probe(7'h34, 1'b1, r); check("R4 alias 0x34", r, 4'b1001);
        probe(7'h44, 1'b0, r); check("R3 outside mask", r, 4'b0000);
    endtask

    task automatic t_equal;
        logic [3:0] r;
        primary_addr = 7'h5A; secondary_addr = 7'h5A; dual_mode = 1;
        probe(7'h5A, 1'b0, r); check("R5 primary priority", r, 4'b1100);
    endtask

    task automatic t_no_strobe;
        primary_addr = 7'h24; dual_mode = 0;
        @(negedge clk);
        rx_byte = {7'h24, 1'b1};
        addr_valid = 0;
        @(negedge clk);
        check("R7 no strobe", {coarse_match, ack, select_secondary, rw}, 4'b0000);
        @(negedge clk);
        check("R7 still quiet", {coarse_match, ack, select_secondary, rw}, 4'b0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_single();
        t_sweep(7'h24, 7'h34, 2, "R3 one bit");
        t_sweep(7'h24, 7'h30, 4, "R3 two bits");
        t_dual_two_bit();
        t_equal();
        t_no_strobe();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule